// File: doc/BRIEF.md
# Spread Spectrum Modulation Profile Generator

This block produces a signed frequency-offset word for each of several fractional-N synthesizer channels. The synthesizer adds the word to its nominal divide ratio, so that its output clock sweeps up and down in frequency once per modulation period. The sweep is a piecewise-linear triangle. It has a programmable dwell at each extreme of the sweep.

Each channel has its own configuration and its own enable:

- a modulation period, counted in reference ticks;
- a dwell length, counted in reference ticks;
- a peak deviation, in units of 1/65536 of nominal;
- a one-bit choice between down spread and center spread.

A shared reference tick advances every running channel by one step. Configuration is sampled only at the start of a modulation period. When a channel is disabled, it finishes its sweep until the profile meets or crosses nominal, and then it holds zero. This keeps the output free of a large frequency step.

Modulation rates of 30 kHz to 120 kHz follow from the tick rate divided by the period count. Down spread from -0.25% to -5% corresponds to peak values of about 164 to 3277. Center spread from ±0.125% to ±2.5% uses the same peak values.

Top module: `ssm_profile_gen`

## Requirements
- R1: While reset is asserted, and after it is released, every offset output reads zero and every channel is idle until a tick arrives with its enable high.
- R2: On a tick where an idle channel's enable is 1, the channel captures its configuration and shows the period-start value: 0 in down mode, and floor(K/2) in center mode (K = peak).
- R3: A running channel advances its phase by one on each tick and by nothing on clocks without a tick. The phase wraps to 0 after P ticks (P = period, P >= 4). Offsets change only on ticks.
- R4: With R = floor(P/2) - D (D = dwell, R taken as 0 if not positive), the level L at phase t is:
  - floor(K*t/R) for t < R (rise);
  - K for R <= t < R+D (top dwell);
  - K - floor(K*(t-R-D)/R) for R+D <= t < 2R+D (fall);
  - 0 for the remaining phases (base dwell).
- R5: When the mode bit is 1 (down spread), the offset equals -L, so it never rises above zero.
- R6: When the mode bit is 0 (center spread), the offset equals floor(K/2) - L.
- R7: Configuration inputs changed during a modulation period have no effect until the phase wraps. The new values apply from phase 0 of the next period.
- R8: With the enable low, a running channel keeps following its profile. On the first tick where the new value is zero, or differs in sign from the present output, or the present output is already zero, the offset becomes 0 and the channel goes idle. Raising the enable again before that tick cancels the shutdown.
- R9: Each channel runs from its own enable and its own configuration. Activity on one channel never changes another channel's offset.
- R10: When R is 0 (D >= floor(P/2)), the level stays 0 for the whole period, so the offset holds its period-start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Reference tick, one clock wide, shared by all channels |
| mod_en | input | NCH | Per-channel modulation enable |
| cfg_period | input | NCH x W | Modulation period in ticks, per channel |
| cfg_dwell | input | NCH x W | Dwell length at each extreme in ticks, per channel |
| cfg_peak | input | NCH x W | Peak deviation in 1/65536 of nominal, per channel |
| cfg_down | input | NCH | Mode select: 1 down spread, 0 center spread |
| offset | output | NCH x OW | Signed two's-complement frequency-offset word, per channel |

## Verification
The profile is swept with several configurations:

- a gentle slope where the peak is much larger than the ramp length but still integer-divisible per step;
- an odd peak in center mode, which separates floor(K/2) from a rounded half;
- a steep slope with zero dwell, where each tick must move the level by several units at once.

These show whether the stepped rise and fall land on exactly floor(K*t/R) and reach K at the top. A degenerate ramp length of zero checks that the level stays flat.

Disabling is tried at three points: mid-ramp in center mode, where a sign change ends the sweep; mid-ramp in down mode with the enable restored before nominal, where the sweep must keep going; and during a flat center profile, where only the switch to down mode at the wrap brings the output to zero.

A configuration change part-way through a period separates an immediate update from one held back until the wrap.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  // Segment of the modulation period that the phase counter sits in.
  typedef enum logic [1:0] {
    SEG_RISE = 2'd0,
    SEG_TOP  = 2'd1,
    SEG_FALL = 2'd2,
    SEG_BASE = 2'd3
  } seg_e;

endpackage

// File: rtl/ssm_slope.sv
// Derives the ramp length of the profile and the per-tick slope,
// split into an integer part and a remainder for error stepping.
module ssm_slope #(
  parameter int W = 16
) (
  input  logic [W-1:0] period,
  input  logic [W-1:0] dwell,
  input  logic [W-1:0] peak,
  output logic [W-1:0] ramp,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);

  logic [W-1:0] half;

  always_comb begin
    half = period >> 1;
    ramp = (half > dwell) ? (half - dwell) : '0;
    if (ramp == '0) begin
      quo = '0;
      rem = '0;
    end else begin
      quo = peak / ramp;
      rem = peak % ramp;
    end
  end

endmodule

// File: rtl/ssm_phase.sv
// Phase accumulator: counts ticks within one modulation period and
// decodes which profile segment the current phase belongs to.
module ssm_phase
  import ssm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         active,
  input  logic         load,
  input  logic [W-1:0] period,
  input  logic [W-1:0] ramp,
  input  logic [W-1:0] dwell,
  output seg_e         seg,
  output logic         wrap
);

  logic [W-1:0] t_q;
  logic [W-1:0] t_d;
  logic [W-1:0] edge_top;
  logic [W-1:0] edge_fall;
  logic [W-1:0] edge_base;

  // next-state
  always_comb begin
    t_d = t_q;
    if (load) begin
      t_d = '0;
    end else if (tick && active) begin
      t_d = t_q + 1'b1;
    end
  end

  // segment decode
  always_comb begin
    edge_top  = ramp;
    edge_fall = ramp + dwell;
    edge_base = edge_fall + ramp;
    if (t_q < edge_top) begin
      seg = SEG_RISE;
    end else if (t_q < edge_fall) begin
      seg = SEG_TOP;
    end else if (t_q < edge_base) begin
      seg = SEG_FALL;
    end else begin
      seg = SEG_BASE;
    end
    wrap = (t_q == (period - 1'b1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '0;
    end else begin
      t_q <= t_d;
    end
  end

  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (t_q < period));

endmodule

// File: rtl/ssm_shaper.sv
// Profile shaper: steps the level along the triangle with an error
// accumulator and maps it onto the signed offset for the chosen mode.
module ssm_shaper
  import ssm_pkg::*;
#(
  parameter int W  = 16,
  parameter int OW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 active,
  input  logic                 load,
  input  logic                 stop,
  input  seg_e                 seg,
  input  logic [W-1:0]         ramp,
  input  logic [W-1:0]         quo,
  input  logic [W-1:0]         rem,
  input  logic [W-1:0]         peak_sh,
  input  logic                 down_sh,
  input  logic [W-1:0]         peak_new,
  input  logic                 down_new,
  output logic signed [OW-1:0] offset,
  output logic signed [OW-1:0] v_next
);

  logic [W-1:0]         lvl_q, lvl_d, lvl_step;
  logic [W-1:0]         err_q, err_d, err_step;
  logic [W-1:0]         sum;
  logic                 carry;
  logic signed [OW-1:0] off_q, off_d;
  logic signed [OW-1:0] v_adv, v_load;
  logic signed [OW-1:0] pk_s, half_s;

  function automatic logic signed [OW-1:0] shape(
    input logic [W-1:0] lv,
    input logic [W-1:0] pk,
    input logic         dn
  );
    logic signed [OW-1:0] l_s;
    logic signed [OW-1:0] h_s;
    l_s = $signed({{(OW-W){1'b0}}, lv});
    h_s = $signed({{(OW-W+1){1'b0}}, pk[W-1:1]});
    return dn ? -l_s : (h_s - l_s);
  endfunction

  // level stepping
  always_comb begin
    sum      = err_q + rem;
    carry    = (ramp != '0) && (sum >= ramp);
    lvl_step = lvl_q;
    err_step = err_q;
    case (seg)
      SEG_RISE: begin
        err_step = carry ? (sum - ramp) : sum;
        lvl_step = lvl_q + quo + {{(W-1){1'b0}}, carry};
      end
      SEG_FALL: begin
        err_step = carry ? (sum - ramp) : sum;
        lvl_step = lvl_q - quo - {{(W-1){1'b0}}, carry};
      end
      default: begin
      end
    endcase
    v_adv  = shape(lvl_step, peak_sh, down_sh);
    v_load = shape({W{1'b0}}, peak_new, down_new);
    v_next = load ? v_load : v_adv;
  end

  // next-state
  always_comb begin
    lvl_d = lvl_q;
    err_d = err_q;
    off_d = off_q;
    if (stop) begin
      lvl_d = '0;
      err_d = '0;
      off_d = '0;
    end else if (load) begin
      lvl_d = '0;
      err_d = '0;
      off_d = v_load;
    end else if (tick && active) begin
      lvl_d = lvl_step;
      err_d = err_step;
      off_d = v_adv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      err_q <= '0;
      off_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      err_q <= err_d;
      off_q <= off_d;
    end
  end

  assign offset = off_q;

  always_comb begin
    pk_s   = $signed({{(OW-W){1'b0}}, peak_sh});
    half_s = $signed({{(OW-W+1){1'b0}}, peak_sh[W-1:1]});
  end

  // R5
  down_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && down_sh) |-> ((off_q <= 0) && (off_q >= -pk_s)));

  // R6
  center_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !down_sh) |-> ((off_q <= half_s) && (off_q >= (half_s - pk_s))));

  // R3
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(off_q));

endmodule

// File: rtl/ssm_channel.sv
// One modulation channel: run control, period-aligned configuration
// shadow, phase accumulator and profile shaper.
module ssm_channel
  import ssm_pkg::*;
#(
  parameter int W  = 16,
  parameter int OW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 en,
  input  logic [W-1:0]         cfg_period,
  input  logic [W-1:0]         cfg_dwell,
  input  logic [W-1:0]         cfg_peak,
  input  logic                 cfg_down,
  output logic signed [OW-1:0] offset
);

  logic                 active_q, active_d;
  logic [W-1:0]         sh_period, sh_dwell, sh_peak;
  logic [W-1:0]         sh_ramp, sh_quo, sh_rem;
  logic                 sh_down;
  logic [W-1:0]         new_ramp, new_quo, new_rem;
  logic                 load, stop, wrap;
  seg_e                 seg;
  logic signed [OW-1:0] v_next;

  ssm_slope #(.W(W)) u_slope (
    .period (cfg_period),
    .dwell  (cfg_dwell),
    .peak   (cfg_peak),
    .ramp   (new_ramp),
    .quo    (new_quo),
    .rem    (new_rem)
  );

  ssm_phase #(.W(W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .active (active_q),
    .load   (load),
    .period (sh_period),
    .ramp   (sh_ramp),
    .dwell  (sh_dwell),
    .seg    (seg),
    .wrap   (wrap)
  );

  ssm_shaper #(.W(W), .OW(OW)) u_shaper (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .active   (active_q),
    .load     (load),
    .stop     (stop),
    .seg      (seg),
    .ramp     (sh_ramp),
    .quo      (sh_quo),
    .rem      (sh_rem),
    .peak_sh  (sh_peak),
    .down_sh  (sh_down),
    .peak_new (cfg_peak),
    .down_new (cfg_down),
    .offset   (offset),
    .v_next   (v_next)
  );

  // run control
  always_comb begin
    load = tick && (active_q ? wrap : en);
    stop = tick && active_q && !en &&
           ((v_next == '0) || (offset == '0) || (v_next[OW-1] != offset[OW-1]));
    active_d = active_q;
    if (stop) begin
      active_d = 1'b0;
    end else if (load) begin
      active_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else begin
      active_q <= active_d;
    end
  end

  // configuration shadow, captured only at a period start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_period <= '0;
      sh_dwell  <= '0;
      sh_peak   <= '0;
      sh_down   <= 1'b0;
      sh_ramp   <= '0;
      sh_quo    <= '0;
      sh_rem    <= '0;
    end else if (load) begin
      sh_period <= cfg_period;
      sh_dwell  <= cfg_dwell;
      sh_peak   <= cfg_peak;
      sh_down   <= cfg_down;
      sh_ramp   <= new_ramp;
      sh_quo    <= new_quo;
      sh_rem    <= new_rem;
    end
  end

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (offset == '0));

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && tick && en) |=> active_q);

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !load) |=> ($stable(sh_period) && $stable(sh_dwell) &&
                             $stable(sh_peak) && $stable(sh_down)));

endmodule

// File: rtl/ssm_profile_gen.sv
// Top: reset release synchronizer and one modulation channel per
// synthesizer, all stepped by a shared reference tick.
module ssm_profile_gen #(
  parameter int NCH = 2,
  parameter int W   = 16,
  parameter int OW  = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [NCH-1:0]           mod_en,
  input  logic [NCH-1:0][W-1:0]    cfg_period,
  input  logic [NCH-1:0][W-1:0]    cfg_dwell,
  input  logic [NCH-1:0][W-1:0]    cfg_peak,
  input  logic [NCH-1:0]           cfg_down,
  output logic [NCH-1:0][OW-1:0]   offset
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ssm_channel #(.W(W), .OW(OW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .tick       (tick),
      .en         (mod_en[g]),
      .cfg_period (cfg_period[g]),
      .cfg_dwell  (cfg_dwell[g]),
      .cfg_peak   (cfg_peak[g]),
      .cfg_down   (cfg_down[g]),
      .offset     (offset[g])
    );
  end

endmodule

// File: tb/tb_ssm_profile_gen.sv
`timescale 1ns/100ps
module tb_ssm_profile_gen;

  localparam int NCH = 2;
  localparam int W   = 16;
  localparam int OW  = 24;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   tick;
  logic [NCH-1:0]         mod_en;
  logic [NCH-1:0][W-1:0]  cfg_period;
  logic [NCH-1:0][W-1:0]  cfg_dwell;
  logic [NCH-1:0][W-1:0]  cfg_peak;
  logic [NCH-1:0]         cfg_down;
  logic [NCH-1:0][OW-1:0] offset;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state, per channel
  int m_run [NCH];
  int m_t   [NCH];
  int m_cur [NCH];
  int m_P   [NCH];
  int m_D   [NCH];
  int m_K   [NCH];
  int m_dn  [NCH];

  always #2.5 clk = ~clk;

  ssm_profile_gen #(.NCH(NCH), .W(W), .OW(OW)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .mod_en     (mod_en),
    .cfg_period (cfg_period),
    .cfg_dwell  (cfg_dwell),
    .cfg_peak   (cfg_peak),
    .cfg_down   (cfg_down),
    .offset     (offset)
  );

  // R4 R5 R6 R10: profile value at phase t
  function automatic int ref_val(input int t, input int p, input int d,
                                 input int k, input int dn);
    int half;
    int r;
    int l;
    half = p / 2;
    r = (half > d) ? (half - d) : 0;
    if (r == 0)              l = 0;
    else if (t < r)          l = (k * t) / r;
    else if (t < r + d)      l = k;
    else if (t < 2 * r + d)  l = k - (k * (t - r - d)) / r;
    else                     l = 0;
    return (dn != 0) ? -l : (k / 2 - l);
  endfunction

  task automatic load_cfg(input int c);
    m_P[c]  = int'(cfg_period[c]);
    m_D[c]  = int'(cfg_dwell[c]);
    m_K[c]  = int'(cfg_peak[c]);
    m_dn[c] = int'(cfg_down[c]);
  endtask

  // R2 R3 R7 R8: one tick of the reference model
  task automatic model_tick(input int c);
    int nt;
    int v;
    if (m_run[c] == 0) begin
      if (mod_en[c]) begin
        load_cfg(c);
        m_t[c]   = 0;
        m_run[c] = 1;
        m_cur[c] = ref_val(0, m_P[c], m_D[c], m_K[c], m_dn[c]);
      end
    end else begin
      if (m_t[c] == m_P[c] - 1) begin
        load_cfg(c);
        nt = 0;
      end else begin
        nt = m_t[c] + 1;
      end
      v = ref_val(nt, m_P[c], m_D[c], m_K[c], m_dn[c]);
      if (!mod_en[c] && (v == 0 || m_cur[c] == 0 || ((v < 0) != (m_cur[c] < 0)))) begin
        m_run[c] = 0;
        m_cur[c] = 0;
      end else begin
        m_t[c]   = nt;
        m_cur[c] = v;
      end
    end
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < NCH; c++) begin
      int got;
      got = $signed(offset[c]);
      checks++;
      if (got != m_cur[c]) begin
        errors++;
        $display("FAIL %s ch%0d offset actual %0d expected %0d", tag, c, got, m_cur[c]);
      end
    end
  endtask

  task automatic do_ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      for (int c = 0; c < NCH; c++) model_tick(c);
      check_all(tag);
    end
  endtask

  task automatic set_cfg(input int c, input int p, input int d, input int k, input int dn);
    cfg_period[c] = W'(p);
    cfg_dwell[c]  = W'(d);
    cfg_peak[c]   = W'(k);
    cfg_down[c]   = dn[0];
  endtask

  // R8: drop all enables and tick until every channel is idle
  task automatic quiesce(input string tag);
    mod_en = '0;
    for (int i = 0; i < 64 && (m_run[0] != 0 || m_run[1] != 0); i++) do_ticks(1, tag);
    check_all(tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick = 1'b0;
    mod_en = '0;
    set_cfg(0, 20, 2, 1000, 1);
    set_cfg(1, 16, 0, 400, 0);
    for (int c = 0; c < NCH; c++) begin
      m_run[c] = 0; m_t[c] = 0; m_cur[c] = 0;
    end
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");
    do_ticks(2, "R1");
  endtask

  task automatic t_down();
    set_cfg(0, 20, 2, 1000, 1);
    mod_en[0] = 1'b1;
    do_ticks(1, "R2");
    do_ticks(24, "R4 R5 R9");
    quiesce("R8");
  endtask

  task automatic t_center();
    set_cfg(0, 24, 3, 1001, 0);
    mod_en[0] = 1'b1;
    do_ticks(1, "R2");
    do_ticks(30, "R6");
    quiesce("R8");
  endtask

  task automatic t_steep();
    set_cfg(0, 12, 0, 3277, 1);
    mod_en[0] = 1'b1;
    do_ticks(14, "R4");
    quiesce("R8");
  endtask

  task automatic t_gap();
    set_cfg(0, 20, 2, 1000, 1);
    mod_en[0] = 1'b1;
    do_ticks(4, "R3");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check_all("R3");
    end
    do_ticks(3, "R3");
    quiesce("R8");
  endtask

  task automatic t_cfg_change();
    set_cfg(0, 16, 1, 800, 1);
    mod_en[0] = 1'b1;
    do_ticks(5, "R7");
    set_cfg(0, 10, 0, 500, 0);
    do_ticks(25, "R7");
    quiesce("R8");
  endtask

  task automatic t_disable();
    set_cfg(0, 24, 3, 1001, 0);
    mod_en[0] = 1'b1;
    do_ticks(3, "R8");
    mod_en[0] = 1'b0;
    do_ticks(6, "R8");
    set_cfg(0, 20, 2, 1000, 1);
    mod_en[0] = 1'b1;
    do_ticks(4, "R8");
    mod_en[0] = 1'b0;
    do_ticks(2, "R8");
    mod_en[0] = 1'b1;
    do_ticks(20, "R8");
    quiesce("R8");
  endtask

  task automatic t_flat();
    set_cfg(0, 8, 5, 900, 0);
    mod_en[0] = 1'b1;
    do_ticks(10, "R10");
    set_cfg(0, 8, 5, 900, 1);
    quiesce("R10");
  endtask

  task automatic t_dual();
    set_cfg(0, 20, 2, 1000, 1);
    set_cfg(1, 14, 1, 700, 0);
    mod_en[0] = 1'b1;
    do_ticks(3, "R9");
    mod_en[1] = 1'b1;
    do_ticks(20, "R9");
    mod_en[0] = 1'b0;
    do_ticks(8, "R9");
    quiesce("R9");
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_down();
    t_center();
    t_steep();
    t_gap();
    t_cfg_change();
    t_disable();
    t_flat();
    t_dual();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog actual running expected finished");
      finish_run();
    end
  end

endmodule